// File: doc/BRIEF.md
# CAN Controller Mode-Control Register File

This block is the small register island that sits between a host bus and the protocol engine of a flexible-data-rate CAN controller. It takes AXI4-Lite accesses and holds the controller enable, a soft-reset trigger, the mode-request register and a bank of sticky error flags. It also reports whether the controller is currently in configuration. It turns the mode requests into a single registered operating-mode code that the protocol engine follows.

Each mode field has its own write rule. Most fields are frozen once the controller is enabled. The sleep request stays writable at all times and is cleared by a wake-up event. The start-recovery request can only be set while the node is in bus-off, and hardware drops it again. Error flags are raised by event pulses from the engine and are cleared by writing ones. After a soft reset the block refuses every access for a fixed number of cycles.

Top module: `canctl_mode_regfile`

Register words (byte offsets, word aligned; any other address is reserved): 0x00 control, 0x04 mode request, 0x08 error flags, 0x0C status.

## Requirements
- R1: After reset, and whenever the enable bit (control bit 1) is 0, `mode_o` is 0 (configuration). All registers read 0 after reset, except status bit 0, which reads 1.
- R2: With enable set and exactly one of sleep (mode bit 0), loopback (mode bit 1) and snoop (mode bit 2) set, `mode_o` is 3, 2 or 4 respectively. With none of them set, `mode_o` is 1 (normal). `mode_o` follows a register write by one extra clock.
- R3: With enable set and two or more of mode bits 0, 1 and 2 set, `mode_o` is 0.
- R4: Mode bits 1, 2, 3, 4, 5 and 7 take written values only while enable is 0. Writes to them while enable is 1 are ignored.
- R5: Mode bit 0 (sleep) is writable at any time. A pulse on `wake_i` clears it, and the wake-up takes priority over a write in the same cycle.
- R6: Mode bit 6 (start recovery) takes a written value only while `busoff_i` is 1. It clears when `recov_done_i` pulses, while enable is 0, and on soft reset.
- R7: Each error-flag bit is set by the matching `err_evt_i` bit and cleared by writing 1 to it at offset 0x08. Writing 0 has no effect, several flags may be set together, and a set in the same cycle as a clear wins.
- R8: A write is accepted only in a cycle where `s_awvalid` and `s_wvalid` are both high. Address or data presented alone changes nothing and produces no response.
- R9: Reserved or unaligned addresses read as 0, and writes to them change nothing.
- R10: Writing 1 to control bit 0 clears enable, the mode register and the error flags. Control bit 0 always reads 0.
- R11: For BUSY_CYC (16) clock edges after a soft-reset write, every access is answered with SLVERR (2'b10). Reads return 0 and writes have no effect. Outside that window, responses are OKAY (2'b00).
- R12: Status bit 0 reads 1 exactly when `mode_o` is 0 (configuration).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | 32 | Write data, all bits applied |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| busoff_i | input | 1 | Protocol engine is in bus-off |
| wake_i | input | 1 | Wake-up event pulse |
| recov_done_i | input | 1 | Bus-off recovery finished pulse |
| err_evt_i | input | ERR_W | Error event pulses, one per flag |
| mode_o | output | 3 | Operating mode: 0 config, 1 normal, 2 loopback, 3 sleep, 4 snoop |

## Verification
A mode bit that slips past its write lock, or one that fails to self-clear, shows up on `mode_o` two edges after the offending write or event, and also on the next read of offset 0x04. A busy counter that is too short or too long changes the response code of the first access at the window edge. A wrong flag-update priority appears in the very next read of the error flags. The bench keeps a cycle-level model of all registers and the mode code, and compares `mode_o` and every response against it on each clock.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  typedef enum logic [2:0] {
    MD_CFG    = 3'd0,
    MD_NORMAL = 3'd1,
    MD_LOOP   = 3'd2,
    MD_SLEEP  = 3'd3,
    MD_SNOOP  = 3'd4
  } op_mode_e;

  // register word indices
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_MODE = 1;
  localparam int unsigned IDX_ERR  = 2;
  localparam int unsigned IDX_STAT = 3;

  // mode register bit positions with special write rules
  localparam int unsigned MB_SLEEP = 0;
  localparam int unsigned MB_LOOP  = 1;
  localparam int unsigned MB_SNOOP = 2;
  localparam int unsigned MB_RECOV = 6;

  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_ERR = 2'b10;
endpackage

// File: rtl/canctl_axil_slave.sv
module canctl_axil_slave
  import canctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  input  logic              busy_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i
);
  logic wr_fire, rd_fire;

  // a write needs both channels in the same cycle
  assign wr_fire   = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign wr_en_o   = wr_fire && !busy_i;
  assign wr_addr_o = s_awaddr;
  assign wr_data_o = s_wdata;

  assign rd_fire   = s_arvalid && !s_rvalid;
  assign s_arready = !s_rvalid;
  assign rd_addr_o = s_araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_bvalid <= 1'b0;
      s_bresp  <= RESP_OK;
    end else if (wr_fire) begin
      s_bvalid <= 1'b1;
      s_bresp  <= busy_i ? RESP_ERR : RESP_OK;
    end else if (s_bready) begin
      s_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
      s_rresp  <= RESP_OK;
    end else if (rd_fire) begin
      s_rvalid <= 1'b1;
      s_rdata  <= busy_i ? '0 : rd_data_i;
      s_rresp  <= busy_i ? RESP_ERR : RESP_OK;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

  assert_busy_err_R11: assert property (@(posedge clk) disable iff (rst)
    (s_awvalid && s_wvalid && !s_bvalid && busy_i) |=> (s_bresp == RESP_ERR));
endmodule

// File: rtl/canctl_reg_core.sv
module canctl_reg_core
  import canctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ERR_W    = 32,
  parameter int BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              busoff_i,
  input  logic              wake_i,
  input  logic              recov_done_i,
  input  logic [ERR_W-1:0]  err_evt_i,
  input  op_mode_e          cur_mode,
  output logic              en_o,
  output logic              sleep_o,
  output logic              loop_o,
  output logic              snoop_o,
  output logic              busy_o
);
  localparam int IW = ADDR_W - 2;
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [7:0] LOCK_MASK = ~((8'd1 << MB_SLEEP) | (8'd1 << MB_RECOV));

  logic             en_q;
  logic [7:0]       mode_q;
  logic [ERR_W-1:0] flags_q;
  logic [BW-1:0]    busy_cnt;
  logic             wr_ctrl, wr_mode, wr_err, soft_rst;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned idx);
    return (a[1:0] == 2'b00) && (a[ADDR_W-1:2] == IW'(idx));
  endfunction

  assign wr_ctrl  = wr_en && hit(wr_addr, IDX_CTRL);
  assign wr_mode  = wr_en && hit(wr_addr, IDX_MODE);
  assign wr_err   = wr_en && hit(wr_addr, IDX_ERR);
  assign soft_rst = wr_ctrl && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= wr_data[1];
      // frozen fields follow writes only while disabled
      if (wr_mode && !en_q)
        mode_q <= (mode_q & ~LOCK_MASK) | (wr_data[7:0] & LOCK_MASK);
      if (wake_i)       mode_q[MB_SLEEP] <= 1'b0;
      else if (wr_mode) mode_q[MB_SLEEP] <= wr_data[MB_SLEEP];
      if (recov_done_i || !en_q)      mode_q[MB_RECOV] <= 1'b0;
      else if (wr_mode && busoff_i)   mode_q[MB_RECOV] <= wr_data[MB_RECOV];
      flags_q <= err_evt_i | (flags_q & ~(wr_err ? wr_data[ERR_W-1:0] : '0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  busy_cnt <= '0;
    else if (soft_rst)        busy_cnt <= BW'(BUSY_CYC);
    else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy_o  = (busy_cnt != '0);
  assign en_o    = en_q;
  assign sleep_o = mode_q[MB_SLEEP];
  assign loop_o  = mode_q[MB_LOOP];
  assign snoop_o = mode_q[MB_SNOOP];

  always_comb begin
    rd_data = '0;
    if (hit(rd_addr, IDX_CTRL))      rd_data[1]         = en_q;
    else if (hit(rd_addr, IDX_MODE)) rd_data[7:0]       = mode_q;
    else if (hit(rd_addr, IDX_ERR))  rd_data[ERR_W-1:0] = flags_q;
    else if (hit(rd_addr, IDX_STAT)) rd_data[0]         = (cur_mode == MD_CFG);
  end

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(soft_rst)) |-> ((mode_q & LOCK_MASK) == ($past(mode_q) & LOCK_MASK)));

  assert_sleep_wake_R5: assert property (@(posedge clk) disable iff (rst)
    $past(wake_i) |-> !mode_q[MB_SLEEP]);

  assert_recov_busoff_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q[MB_RECOV]) |-> $past(busoff_i));

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
    ((flags_q & ~$past(flags_q) & ~$past(err_evt_i)) == '0));

  assert_busy_after_srst_R11: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> busy_o);
endmodule

// File: rtl/canctl_mode_dec.sv
module canctl_mode_dec
  import canctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en_i,
  input  logic     sleep_i,
  input  logic     loop_i,
  input  logic     snoop_i,
  output op_mode_e mode_o
);
  logic [2:0] req;
  logic       multi;
  op_mode_e   nxt;

  assign req   = {snoop_i, loop_i, sleep_i};
  assign multi = |(req & (req - 3'd1));

  always_comb begin
    if (!en_i || multi) nxt = MD_CFG;
    else if (sleep_i)   nxt = MD_SLEEP;
    else if (loop_i)    nxt = MD_LOOP;
    else if (snoop_i)   nxt = MD_SNOOP;
    else                nxt = MD_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_o <= MD_CFG;
    else     mode_o <= nxt;
  end

  assert_loop_only_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_LOOP) |-> $past(en_i && loop_i && !sleep_i && !snoop_i));

  assert_multi_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && ($countones($past(req)) > 1)) |-> (mode_o == MD_CFG));

  assert_disabled_cfg_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (mode_o == MD_CFG));
endmodule

// File: rtl/canctl_mode_regfile.sv
module canctl_mode_regfile
  import canctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ERR_W    = 32,
  parameter int BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  input  logic              busoff_i,
  input  logic              wake_i,
  input  logic              recov_done_i,
  input  logic [ERR_W-1:0]  err_evt_i,
  output logic [2:0]        mode_o
);
  logic              busy, wr_en, en, sleep, loop, snoop;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_data;
  op_mode_e          cur_mode;

  canctl_axil_slave #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .busy_i(busy), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  canctl_reg_core #(.ADDR_W(ADDR_W), .ERR_W(ERR_W), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busoff_i(busoff_i), .wake_i(wake_i), .recov_done_i(recov_done_i),
    .err_evt_i(err_evt_i), .cur_mode(cur_mode),
    .en_o(en), .sleep_o(sleep), .loop_o(loop), .snoop_o(snoop), .busy_o(busy)
  );

  canctl_mode_dec u_mode (
    .clk(clk), .rst(rst), .en_i(en),
    .sleep_i(sleep), .loop_i(loop), .snoop_i(snoop), .mode_o(cur_mode)
  );

  assign mode_o = cur_mode;
endmodule

// File: tb/canctl_mode_regfile_tb.sv
module canctl_mode_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [7:0]  awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        busoff = 0, wake = 0, recov = 0;
  logic [31:0] err_evt = 0;
  logic [2:0]  mode_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  canctl_mode_regfile u_dut (
    .clk(clk), .rst(rst),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .busoff_i(busoff), .wake_i(wake), .recov_done_i(recov),
    .err_evt_i(err_evt), .mode_o(mode_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_en, m_bv, m_rv;
  logic [7:0]  m_md;
  logic [31:0] m_fl, e_rd;
  logic [1:0]  e_rr, e_br;
  logic [2:0]  m_out;
  int          m_busy;

  function automatic logic [2:0] mfn(input logic en, input logic [7:0] md);
    int n;
    n = md[0] + md[1] + md[2];
    if (!en || n > 1) return 3'd0;
    if (md[0]) return 3'd3;
    if (md[1]) return 3'd2;
    if (md[2]) return 3'd4;
    return 3'd1;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    case (a)
      8'h00:   return {30'd0, m_en, 1'b0};
      8'h04:   return {24'd0, m_md};
      8'h08:   return m_fl;
      8'h0C:   return {31'd0, (m_out == 3'd0)};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic wf, rf, bz, oen, acc;
    logic [2:0] nout;
    logic [7:0] nm;
    if (rst) begin
      m_en = 0; m_md = 0; m_fl = 0; m_busy = 0; m_bv = 0; m_rv = 0;
      m_out = 0; e_rd = 0; e_rr = 0; e_br = 0;
    end else begin
      bz = (m_busy > 0);
      wf = awvalid && wvalid && !m_bv;
      rf = arvalid && !m_rv;
      acc = wf && !bz;
      if (rf) begin m_rv = 1; e_rr = bz ? 2'd2 : 2'd0; e_rd = bz ? 32'd0 : mread(araddr); end
      else if (rready) m_rv = 0;
      if (wf) begin m_bv = 1; e_br = bz ? 2'd2 : 2'd0; end
      else if (bready) m_bv = 0;
      nout = mfn(m_en, m_md);
      if (m_busy > 0) m_busy--;
      if (acc && awaddr == 8'h00 && wdata[0]) begin
        m_en = 0; m_md = 0; m_fl = 0; m_busy = 16;
      end else begin
        oen = m_en;
        nm = m_md;
        if (acc && awaddr == 8'h00) m_en = wdata[1];
        if (acc && awaddr == 8'h04) begin
          if (!oen) begin nm[5:1] = wdata[5:1]; nm[7] = wdata[7]; end
          nm[0] = wdata[0];
          if (busoff) nm[6] = wdata[6];
        end
        if (wake) nm[0] = 0;
        if (recov || !oen) nm[6] = 0;
        m_md = nm;
        if (acc && awaddr == 8'h08) m_fl = m_fl & ~wdata;
        m_fl = m_fl | err_evt;
      end
      m_out = nout;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 mode_o vs model", {29'd0, mode_o}, {29'd0, m_out});
      if (rvalid) begin
        chk("R9 rdata vs model", rdata, e_rd);
        chk("R11 rresp vs model", {30'd0, rresp}, {30'd0, e_rr});
      end
      if (bvalid) chk("R11 bresp vs model", {30'd0, bresp}, {30'd0, e_br});
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [1:0]  br, rr;
  logic [31:0] rv;

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic [1:0] resp);
    @(negedge clk); awvalid = 1; wvalid = 1; awaddr = a; wdata = d;
    @(negedge clk); awvalid = 0; wvalid = 0; resp = bresp;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk); arvalid = 1; araddr = a;
    @(negedge clk); arvalid = 0; d = rdata; resp = rresp;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd(a, rv, rr);
    chk(tag, rv, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode after reset", {29'd0, mode_o}, 0);
    rdchk(8'h00, 0, "R1 control after reset");
    rdchk(8'h04, 0, "R1 mode reg after reset");
    rdchk(8'h08, 0, "R1 flags after reset");
    rdchk(8'h0C, 1, "R12 status config after reset");

    // loopback requested while disabled, then enable
    wr(8'h04, 32'h02, br);
    rdchk(8'h04, 32'h02, "R4 mode writable while disabled");
    chk("R1 still config while disabled", {29'd0, mode_o}, 0);
    wr(8'h00, 32'h02, br);
    chk("R2 loopback", {29'd0, mode_o}, 2);
    rdchk(8'h0C, 0, "R12 status clear when running");
    rdchk(8'h00, 32'h02, "R10 enable readback, reset bit reads 0");

    // locked fields while enabled
    wr(8'h04, 32'hBC, br);
    rdchk(8'h04, 32'h02, "R4 locked bits ignored while enabled");
    chk("R4 mode unchanged", {29'd0, mode_o}, 2);

    // sleep writable while enabled -> two requests -> config
    wr(8'h04, 32'h03, br);
    rdchk(8'h04, 32'h03, "R5 sleep writable while enabled");
    chk("R3 two requests give config", {29'd0, mode_o}, 0);
    rdchk(8'h0C, 1, "R12 status set on conflict");
    @(negedge clk); wake = 1; @(negedge clk); wake = 0; @(negedge clk);
    rdchk(8'h04, 32'h02, "R5 wake clears sleep");
    chk("R5 back to loopback", {29'd0, mode_o}, 2);

    // each single request
    wr(8'h00, 0, br); wr(8'h04, 32'h01, br); wr(8'h00, 32'h02, br);
    chk("R2 sleep mode", {29'd0, mode_o}, 3);
    wr(8'h00, 0, br); wr(8'h04, 32'h04, br); wr(8'h00, 32'h02, br);
    chk("R2 snoop mode", {29'd0, mode_o}, 4);
    wr(8'h00, 0, br); wr(8'h04, 32'h06, br); wr(8'h00, 32'h02, br);
    chk("R3 loopback+snoop gives config", {29'd0, mode_o}, 0);
    wr(8'h00, 0, br); wr(8'h04, 0, br); wr(8'h00, 32'h02, br);
    chk("R2 normal mode", {29'd0, mode_o}, 1);

    // start-recovery bit rules
    wr(8'h04, 32'h40, br);
    rdchk(8'h04, 0, "R6 recovery bit ignored outside bus-off");
    busoff = 1;
    wr(8'h04, 32'h40, br);
    rdchk(8'h04, 32'h40, "R6 recovery bit set in bus-off");
    @(negedge clk); recov = 1; @(negedge clk); recov = 0; @(negedge clk);
    rdchk(8'h04, 0, "R6 recovery done clears bit");
    wr(8'h04, 32'h40, br);
    wr(8'h00, 0, br);
    rdchk(8'h04, 0, "R6 disable clears recovery bit");
    busoff = 0;

    // error flags
    @(negedge clk); err_evt = 32'h05; @(negedge clk); err_evt = 0;
    rdchk(8'h08, 32'h05, "R7 events set several flags");
    wr(8'h08, 0, br);
    rdchk(8'h08, 32'h05, "R7 writing 0 keeps flags");
    wr(8'h08, 32'h04, br);
    rdchk(8'h08, 32'h01, "R7 write 1 clears one flag");
    err_evt = 32'h01;
    wr(8'h08, 32'h01, br);
    err_evt = 0;
    rdchk(8'h08, 32'h01, "R7 set wins over clear");
    wr(8'h08, 32'hFFFF_FFFF, br);
    rdchk(8'h08, 0, "R7 clear all");

    // reserved addresses
    wr(8'h20, 32'hFFFF_FFFF, br);
    chk("R9 reserved write OKAY", {30'd0, br}, 0);
    rdchk(8'h20, 0, "R9 reserved reads 0");
    wr(8'h05, 32'hFF, br);
    rdchk(8'h05, 0, "R9 unaligned reads 0");
    rdchk(8'h04, 0, "R9 unaligned write no effect");

    // split channels never write
    @(negedge clk); awvalid = 1; awaddr = 8'h04; wdata = 32'h02;
    repeat (2) @(negedge clk); awvalid = 0; wvalid = 1;
    repeat (2) @(negedge clk); wvalid = 0;
    chk("R8 no response for split channels", {31'd0, bvalid}, 0);
    rdchk(8'h04, 0, "R8 split channels do not write");

    // soft reset and busy window
    @(negedge clk); err_evt = 32'h80; @(negedge clk); err_evt = 0;
    wr(8'h04, 32'h02, br); wr(8'h00, 32'h02, br);
    chk("R2 loopback before soft reset", {29'd0, mode_o}, 2);
    wr(8'h00, 32'h03, br);
    chk("R10 soft reset write OKAY", {30'd0, br}, 0);
    rd(8'h04, rv, rr);
    chk("R11 read during busy SLVERR", {30'd0, rr}, 2);
    chk("R11 read during busy returns 0", rv, 0);
    wr(8'h04, 32'h01, br);
    chk("R11 write during busy SLVERR", {30'd0, br}, 2);
    chk("R10 config after soft reset", {29'd0, mode_o}, 0);
    repeat (20) @(negedge clk);
    rd(8'h00, rv, rr);
    chk("R11 OKAY after busy window", {30'd0, rr}, 0);
    chk("R10 enable cleared", rv, 0);
    rdchk(8'h04, 0, "R11 busy write ignored, R10 mode cleared");
    rdchk(8'h08, 0, "R10 flags cleared");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule